// File: doc/BRIEF.md
# Temporal Multithread Switch Controller

This block decides which of two hardware threads owns a single in-order core. Only one thread issues at any time. The controller watches the running thread and hands the core to the other thread on one of three events: the thread has used up its time slice, it has retired nothing for a programmable number of cycles, or it has taken a long-latency miss. The other thread can then use the cycles the first thread would have spent idle.

Each thread has its own slice length, and that length adapts. A thread that runs its whole slice while still making progress gets a longer slice next time. A thread that is switched out for lack of progress gets a shorter one. A switch is never forced onto a thread that is not ready; the current thread keeps the core instead. Every real switch costs a fixed number of dead cycles. During those cycles a busy output holds issue off. The reset input is asserted asynchronously and must be released in step with the clock.

Top module: `mtsw_ctrl`

## Requirements
- R1: Out of reset, thread 0 is active (`active_tid` = 0), `switch_busy` is low, and both slice lengths equal `QINIT`.
- R2: At most one thread is active at a time. `active_tid` changes only in the cycle in which `switch_busy` rises.
- R3: A thread has used its slice when it has had as many run cycles (cycles with `switch_busy` low) as its current slice length. That cycle is a trigger.
- R4: A run cycle with `long_miss` high is a trigger.
- R5: A run cycle with `retire_cnt` = 0 that ends a run of `win_len` consecutive zero-retire run cycles is a stall trigger. A `win_len` of 0 acts as 1.
- R6: A trigger while `thr_ready[other thread]` is low causes no switch. The same thread keeps running, and its slice and zero-retire counts restart from zero.
- R7: A trigger while the other thread is ready flips `active_tid` and raises `switch_busy` on the next cycle. `switch_busy` then stays high for exactly `PENALTY` cycles. While it is high, `retire_cnt` and `long_miss` are ignored, and slice counting resumes from zero for the new thread.
- R8: A trigger that is a slice expiry with neither a stall nor a miss in the same cycle doubles that thread's slice length, saturating at `QMAX`.
- R9: A trigger that includes a stall halves that thread's slice length, flooring at `QMIN`. This holds even when expiry or a miss falls in the same cycle.
- R10: A trigger that includes a miss but no stall leaves the slice length unchanged, even when expiry falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_cnt | input | RET_W | Instructions retired by the active thread this cycle |
| long_miss | input | 1 | Active thread took a long-latency miss this cycle |
| thr_ready | input | 2 | Per-thread ready flags, bit n for thread n |
| win_len | input | WIN_W | Zero-retire cycles that count as no progress |
| active_tid | output | 1 | Thread that currently owns the core |
| switch_busy | output | 1 | Switch in progress; issue must be blocked |

## Verification
Slice expiry can land in the same run cycle as a long miss or a stall, and the slice-length update must then follow the priority in R9 and R10. The bench uses its own model's count of run cycles to find the exact cycle in which a slice ends. In that cycle it drives a miss, or a one-cycle window with zero retirement. It then judges the outcome by the length of the thread's next run before the following switch, which the model predicts cycle by cycle.

// File: rtl/mtsw_pkg.sv
package mtsw_pkg;

  // Kind of slice-length update applied to the outgoing thread
  typedef enum logic [1:0] {
    ADJ_KEEP   = 2'd0,
    ADJ_GROW   = 2'd1,
    ADJ_SHRINK = 2'd2
  } adj_e;

  // Switch sequencer state
  typedef enum logic {
    SEQ_RUN  = 1'b0,
    SEQ_SWAP = 1'b1
  } seq_e;

  // Trigger causes seen in one run cycle
  typedef struct packed {
    logic expire;
    logic stall;
    logic miss;
  } trig_t;

  // Stall wins over miss, and miss wins over plain expiry
  function automatic adj_e adj_pick(trig_t t);
    if (t.stall)  return ADJ_SHRINK;
    if (t.miss)   return ADJ_KEEP;
    if (t.expire) return ADJ_GROW;
    return ADJ_KEEP;
  endfunction

endpackage

// File: rtl/mtsw_watch.sv
module mtsw_watch
  import mtsw_pkg::*;
#(
  parameter int QW    = 6,
  parameter int WIN_W = 4,
  parameter int RET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic             long_miss,
  input  logic [WIN_W-1:0] win_len,
  input  logic [QW-1:0]    cur_qlen,
  output trig_t            trig,
  output logic             fire
);

  localparam logic [WIN_W-1:0] IDLE_TOP = '1;

  logic [QW-1:0]    used_q, used_d;
  logic [WIN_W-1:0] idle_q, idle_d;
  logic [WIN_W-1:0] win_lim;
  logic             none_retired;
  logic             cnt_en;

  // Trigger detection for the current run cycle
  always_comb begin
    none_retired = (retire_cnt == '0);
    win_lim      = (win_len == '0) ? '0 : (win_len - WIN_W'(1));
    trig.expire  = run && (used_q >= (cur_qlen - QW'(1)));
    trig.stall   = run && none_retired && (idle_q >= win_lim);
    trig.miss    = run && long_miss;
    fire         = trig.expire || trig.stall || trig.miss;
  end

  // Slice-use and zero-retire counters, next state
  always_comb begin
    used_d = used_q;
    idle_d = idle_q;
    cnt_en = run;
    if (fire) begin
      used_d = '0;
      idle_d = '0;
    end else if (run) begin
      used_d = used_q + QW'(1);
      if (!none_retired) begin
        idle_d = '0;
      end else if (idle_q != IDLE_TOP) begin
        idle_d = idle_q + WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      idle_q <= '0;
    end else if (cnt_en) begin
      used_q <= used_d;
      idle_q <= idle_d;
    end
  end

endmodule

// File: rtl/mtsw_qtable.sv
module mtsw_qtable
  import mtsw_pkg::*;
#(
  parameter int NTHR  = 2,
  parameter int TW    = 1,
  parameter int QW    = 6,
  parameter int QMIN  = 4,
  parameter int QMAX  = 32,
  parameter int QINIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [TW-1:0]    upd_tid,
  input  adj_e             upd_kind,
  input  logic [TW-1:0]    rd_tid,
  output logic [QW-1:0]    rd_qlen,
  output logic [NTHR*QW-1:0] qlen_all
);

  localparam logic [QW:0]   QMAX_X  = (QW+1)'(QMAX);
  localparam logic [QW-1:0] QMAX_Q  = QW'(QMAX);
  localparam logic [QW-1:0] QMIN_Q  = QW'(QMIN);
  localparam logic [QW-1:0] QINIT_Q = QW'(QINIT);

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic [QW-1:0] q_q, q_d;
    logic [QW:0]   dbl;
    logic [QW-1:0] hlf;
    logic          wr;

    always_comb begin
      dbl = {q_q, 1'b0};
      hlf = q_q >> 1;
      wr  = upd_en && (upd_tid == TW'(g));
      q_d = q_q;
      case (upd_kind)
        ADJ_GROW:   q_d = (dbl >= QMAX_X) ? QMAX_Q : dbl[QW-1:0];
        ADJ_SHRINK: q_d = (hlf <= QMIN_Q) ? QMIN_Q : hlf;
        default:    q_d = q_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_q <= QINIT_Q;
      end else if (wr) begin
        q_q <= q_d;
      end
    end

    assign qlen_all[g*QW +: QW] = q_q;
  end

  assign rd_qlen = qlen_all[rd_tid*QW +: QW];

endmodule

// File: rtl/mtsw_seq.sv
module mtsw_seq
  import mtsw_pkg::*;
#(
  parameter int PENALTY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic other_ready,
  output logic tid,
  output logic busy
);

  localparam int PW = (PENALTY < 2) ? 1 : $clog2(PENALTY);
  localparam logic [PW-1:0] PEN_LOAD = PW'(PENALTY - 1);

  seq_e          state_q, state_d;
  logic          tid_q, tid_d;
  logic [PW-1:0] pen_q, pen_d;
  logic          seq_en;

  always_comb begin
    state_d = state_q;
    tid_d   = tid_q;
    pen_d   = pen_q;
    seq_en  = (state_q == SEQ_SWAP) || fire;
    case (state_q)
      SEQ_RUN: begin
        if (fire && other_ready) begin
          state_d = SEQ_SWAP;
          tid_d   = ~tid_q;
          pen_d   = PEN_LOAD;
        end
      end
      SEQ_SWAP: begin
        if (pen_q == '0) begin
          state_d = SEQ_RUN;
        end else begin
          pen_d = pen_q - PW'(1);
        end
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      tid_q   <= 1'b0;
      pen_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      tid_q   <= tid_d;
      pen_q   <= pen_d;
    end
  end

  assign tid  = tid_q;
  assign busy = (state_q == SEQ_SWAP);

endmodule

// File: rtl/mtsw_ctrl.sv
module mtsw_ctrl
  import mtsw_pkg::*;
#(
  parameter int QMIN    = 4,
  parameter int QMAX    = 32,
  parameter int QINIT   = 8,
  parameter int PENALTY = 3,
  parameter int WIN_W   = 4,
  parameter int RET_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic             long_miss,
  input  logic [1:0]       thr_ready,
  input  logic [WIN_W-1:0] win_len,
  output logic             active_tid,
  output logic             switch_busy
);

  localparam int NTHR = 2;
  localparam int TW   = 1;
  localparam int QW   = $clog2(QMAX + 1);

  trig_t              trig;
  logic               fire;
  logic               run;
  logic               other_ready;
  logic [QW-1:0]      cur_qlen;
  logic [NTHR*QW-1:0] qlen_all;
  adj_e               adj_kind;

  assign run         = ~switch_busy;
  assign other_ready = thr_ready[~active_tid];
  assign adj_kind    = adj_pick(trig);

  mtsw_watch #(
    .QW    (QW),
    .WIN_W (WIN_W),
    .RET_W (RET_W)
  ) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .retire_cnt (retire_cnt),
    .long_miss  (long_miss),
    .win_len    (win_len),
    .cur_qlen   (cur_qlen),
    .trig       (trig),
    .fire       (fire)
  );

  mtsw_qtable #(
    .NTHR  (NTHR),
    .TW    (TW),
    .QW    (QW),
    .QMIN  (QMIN),
    .QMAX  (QMAX),
    .QINIT (QINIT)
  ) u_qtab (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (fire),
    .upd_tid  (active_tid),
    .upd_kind (adj_kind),
    .rd_tid   (active_tid),
    .rd_qlen  (cur_qlen),
    .qlen_all (qlen_all)
  );

  mtsw_seq #(
    .PENALTY (PENALTY)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .other_ready (other_ready),
    .tid         (active_tid),
    .busy        (switch_busy)
  );

endmodule

// File: rtl/mtsw_ctrl_chk.sv
module mtsw_ctrl_chk #(
  parameter int QW      = 6,
  parameter int QMIN    = 4,
  parameter int QMAX    = 32,
  parameter int PENALTY = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          long_miss,
  input logic [1:0]    thr_ready,
  input logic          active_tid,
  input logic          switch_busy,
  input logic [2*QW-1:0] qlen_all
);

  localparam int CW = $clog2(PENALTY + 2);

  logic [CW-1:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run_q <= '0;
    end else begin
      busy_run_q <= switch_busy ? (busy_run_q + CW'(1)) : '0;
    end
  end

  AST_TID_AT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_tid != $past(active_tid)) |-> $rose(switch_busy)); // R2

  AST_MISS_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!switch_busy && long_miss && thr_ready[~active_tid]) |=> (switch_busy && (active_tid != $past(active_tid)))); // R4

  AST_HOLD_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!switch_busy && !thr_ready[~active_tid]) |=> (!switch_busy && $stable(active_tid))); // R6

  AST_PENALTY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    switch_busy |-> (busy_run_q < CW'(PENALTY))); // R7

  AST_PENALTY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(switch_busy) |-> (busy_run_q == CW'(PENALTY))); // R7

  for (genvar g = 0; g < 2; g++) begin : g_rng
    AST_QLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (qlen_all[g*QW +: QW] >= QW'(QMIN)) && (qlen_all[g*QW +: QW] <= QW'(QMAX))); // R9
  end

endmodule

bind mtsw_ctrl mtsw_ctrl_chk #(
  .QW      (QW),
  .QMIN    (QMIN),
  .QMAX    (QMAX),
  .PENALTY (PENALTY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .long_miss   (long_miss),
  .thr_ready   (thr_ready),
  .active_tid  (active_tid),
  .switch_busy (switch_busy),
  .qlen_all    (qlen_all)
);

// File: tb/mtsw_ctrl_test.sv
module mtsw_ctrl_test;

  localparam int QMIN    = 4;
  localparam int QMAX    = 32;
  localparam int QINIT   = 8;
  localparam int PENALTY = 3;
  localparam int WIN_W   = 4;
  localparam int RET_W   = 3;
  localparam int WDOG    = 100000;

  logic             clk;
  logic             rst_n;
  logic [RET_W-1:0] retire_cnt;
  logic             long_miss;
  logic [1:0]       thr_ready;
  logic [WIN_W-1:0] win_len;
  logic             active_tid;
  logic             switch_busy;

  mtsw_ctrl #(
    .QMIN(QMIN), .QMAX(QMAX), .QINIT(QINIT),
    .PENALTY(PENALTY), .WIN_W(WIN_W), .RET_W(RET_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .long_miss(long_miss),
    .thr_ready(thr_ready), .win_len(win_len),
    .active_tid(active_tid), .switch_busy(switch_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string tag    = "R1";

  // Behavioural reference state
  int m_tid, m_busy, m_pen, m_used, m_idle;
  int m_q [2];
  int busy_len = 0;
  bit prev_busy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tid = 0; m_busy = 0; m_pen = 0; m_used = 0; m_idle = 0;
      m_q[0] = QINIT; m_q[1] = QINIT;
    end else if (m_busy != 0) begin
      if (m_pen == 0) m_busy = 0;
      else m_pen = m_pen - 1;
    end else begin
      int  w;
      bit  ex, st, ms;
      w  = (win_len == 0) ? 1 : int'(win_len);
      ex = (m_used + 1 >= m_q[m_tid]);
      st = (retire_cnt == 0) && (m_idle + 1 >= w);
      ms = long_miss;
      if (ex || st || ms) begin
        if (st) m_q[m_tid] = (m_q[m_tid] / 2 <= QMIN) ? QMIN : m_q[m_tid] / 2;
        else if (!ms) m_q[m_tid] = (m_q[m_tid] * 2 >= QMAX) ? QMAX : m_q[m_tid] * 2;
        m_used = 0;
        m_idle = 0;
        if (thr_ready[1 - m_tid]) begin
          m_tid  = 1 - m_tid;
          m_busy = 1;
          m_pen  = PENALTY - 1;
        end
      end else begin
        m_used = m_used + 1;
        m_idle = (retire_cnt == 0) ? m_idle + 1 : 0;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  // One cycle: wait for the falling edge, compare, then let the caller drive
  task automatic step();
    @(negedge clk);
    if (cmp_on) begin
      chk({tag, " R2"}, "active_tid", int'(active_tid), m_tid);
      chk({tag, " R7"}, "switch_busy", int'(switch_busy), m_busy);
      if (switch_busy) busy_len++;
      if (prev_busy && !switch_busy) begin
        chk("R7", "penalty length", busy_len, PENALTY);
        busy_len = 0;
      end
      prev_busy = switch_busy;
    end
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst_n = 1'b0; retire_cnt = '0; long_miss = 1'b0;
    thr_ready = 2'b11; win_len = 4'd15;
    repeat (3) @(negedge clk);
    chk("R1", "reset tid", int'(active_tid), 0);
    chk("R1", "reset busy", int'(switch_busy), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // Progress-making threads: expiry switches and slice growth
    tag = "R3 R8";
    retire_cnt = 3'd2;
    run_cycles(300);

    // No retirement: stall triggers shrink slices
    tag = "R5 R9";
    retire_cnt = 3'd0; win_len = 4'd5;
    run_cycles(150);

    // Zero window behaves as a one-cycle window
    tag = "R5 win0";
    win_len = 4'd0;
    run_cycles(40);

    // Periodic long misses, slices untouched by them
    tag = "R4 R10";
    retire_cnt = 3'd1; win_len = 4'd15;
    for (int i = 0; i < 30; i++) begin
      long_miss = 1'b1; step();
      long_miss = 1'b0; run_cycles(7);
    end

    // Other thread not ready: triggers keep the current thread
    tag = "R6";
    retire_cnt = 3'd0; win_len = 4'd3;
    for (int i = 0; i < 6; i++) begin
      thr_ready = (m_tid == 0) ? 2'b01 : 2'b10;
      long_miss = (i % 2 == 1);
      run_cycles(20);
      long_miss = 1'b0;
      thr_ready = 2'b11;
      run_cycles(12);
    end

    // Expiry coinciding with a miss or with a stall
    tag = "R9 R10 same-cycle";
    for (int i = 0; i < 10; i++) begin
      retire_cnt = 3'd1; win_len = 4'd15; long_miss = 1'b0; thr_ready = 2'b11;
      for (int k = 0; k < 200; k++) begin
        if (m_busy == 0 && m_used + 1 >= m_q[m_tid]) break;
        step();
      end
      if (i % 2 == 0) long_miss = 1'b1;
      else begin win_len = 4'd1; retire_cnt = 3'd0; end
      step();
      long_miss = 1'b0; win_len = 4'd15; retire_cnt = 3'd1;
      run_cycles(40);
    end

    // Mixed traffic
    tag = "R3 R4 R5 R6 mix";
    for (int i = 0; i < 3000; i++) begin
      retire_cnt = (($urandom % 3) == 0) ? 3'd0 : 3'($urandom % 5);
      long_miss  = (($urandom % 20) == 0);
      thr_ready  = (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'b11;
      if (($urandom % 50) == 0) win_len = 4'($urandom % 7);
      step();
    end

    long_miss = 1'b0;
    run_cycles(5);
    done = 1;
    summary();
    $finish;
  end

endmodule